// File: doc/BRIEF.md
# Priority-Based Port Power Allocator

This block shares a fixed supply budget among a fixed number of powered ports. When a port finishes classification it raises a one-cycle request. The block works out the power that port should get from its class result, capped by a per-port host limit and a hard safety ceiling. An ambiguous class gets a small conservative figure instead. The block then compares the requested power with the headroom that is left. The headroom is the total budget minus the current sum of allocations, minus a guard margin. The request is granted in full, granted at the reduced headroom (downgraded), or denied. A new request never takes power away from a port that is already on.

The total budget and the guard margin are live inputs. If they change so that the allocated sum plus the guard exceeds the total, the block switches off powered ports one per cycle until the budget fits again. It picks the lowest-priority port first, and among ports of equal priority the one admitted most recently. A port that was shed must wait out a backoff window before it can be admitted again. A policy table holds the priority, strictness and host cap of each port and carries a version number. The table is loaded all at once on a commit strobe. Every grant, downgrade, denial, shed and release is reported as one event that carries the port index and a code.

Top module: `pa_alloc`

## Requirements
- R1: The class-derived power is (class+1)*8, or 8 when the ambiguous flag is set. The target is the smallest of that figure, the port's host cap and the safety cap of 60. No allocation ever exceeds 60.
- R2: The headroom is total − sum − guard, and 0 when that value is negative. A request whose target is at most the headroom is granted in full. The equal case counts as a fit. A full grant sets the port on and reports event code 0.
- R3: When the target exceeds the headroom, the result depends on the port's strict bit. A non-strict port gets the headroom as its allocation if the headroom is at least 4, and event code 1 is reported. Otherwise the request is denied with code 2. A denial changes no allocation and no other port's on state.
- R4: When sum + guard > total, exactly one powered port is shed per cycle. The shed port is the one with the lowest priority value. Its allocation is freed, shed_o pulses for that port and event code 4 is reported. No shed occurs while sum + guard ≤ total.
- R5: Among powered ports of equal priority, the most recently admitted port is shed first.
- R6: A shed port gets a backoff of 16 cycles. A request from that port while its backoff is still running is denied with code 3.
- R7: One action is taken per clock, in this order: a shed, then a pending release, then a pending request. Pending releases and requests are served in ascending port index order, one per cycle.
- R8: The priority, strict bit, cap and version are loaded together on cfg_commit_i and take effect on the next cycle. Table inputs that are not committed have no effect. ver_o shows the committed version.
- R9: sum_o always equals the sum of all per-port allocations. It is updated in the same cycle as the grant, downgrade, shed or release that changes it.
- R10: A release of a powered port frees its allocation, clears its on state and reports code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NPORT | One-cycle request per port after classification |
| cls_i | input | NPORT*CW | Class result per port, held while the request is pending |
| amb_i | input | NPORT | Class result is ambiguous |
| rel_i | input | NPORT | One-cycle release per port |
| total_i | input | SUMW | Total supply budget |
| guard_i | input | SUMW | Guard margin kept unallocated |
| cfg_pri_i | input | NPORT*PRIW | Staged priority per port (higher value is kept longer) |
| cfg_strict_i | input | NPORT | Staged strict bit: 1 = deny rather than downgrade |
| cfg_cap_i | input | NPORT*PW | Staged host cap per port |
| cfg_ver_i | input | VW | Staged table version |
| cfg_commit_i | input | 1 | Load all staged table fields at once |
| on_o | output | NPORT | Port is powered |
| shed_o | output | NPORT | One-cycle shed pulse |
| alloc_o | output | NPORT*PW | Allocated power per port |
| sum_o | output | SUMW | Sum of allocations |
| evt_v_o | output | 1 | Event valid |
| evt_port_o | output | IW | Port the event names |
| evt_code_o | output | 3 | 0 grant, 1 downgrade, 2 deny budget, 3 deny backoff, 4 shed, 5 release |
| ver_o | output | VW | Committed table version |

## Verification
A table of class, ambiguity and host-cap combinations is applied to a single port with ample budget. This separates the class formula, the conservative figure for ambiguous classes, the host cap and the safety cap. Directed sequences then fill the budget. They tell apart three outcomes: a full grant, including the exact-fit boundary; a downgrade; and a strict denial. Lowering the total budget step by step shows that shedding follows priority first and recency second, and that it stops at the boundary where the budget fits exactly. Requests that arrive together, requests made during the backoff window, and table inputs that were never committed show the ordering, the backoff and the atomic table update.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [2:0] {
        EV_GRANT     = 3'd0,
        EV_DOWN      = 3'd1,
        EV_DENY_BUD  = 3'd2,
        EV_DENY_BOFF = 3'd3,
        EV_SHED      = 3'd4,
        EV_REL       = 3'd5
    } ev_code_e;
endpackage

// File: rtl/pa_first_set.sv
// Lowest set index of a vector.
module pa_first_set #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/pa_victim.sv
// Picks the powered port with lowest priority; ties go to the lowest rank
// (rank 0 = most recently admitted).
module pa_victim #(
    parameter int N    = 4,
    parameter int IW   = 2,
    parameter int PRIW = 2,
    parameter int RW   = 3
) (
    input  logic [N-1:0]           on_i,
    input  logic [N-1:0][PRIW-1:0] pri_i,
    input  logic [N-1:0][RW-1:0]   rank_i,
    output logic                   found_o,
    output logic [IW-1:0]          idx_o
);
    logic [PRIW-1:0] best_pri;
    logic [RW-1:0]   best_rank;

    always_comb begin
        found_o   = 1'b0;
        idx_o     = '0;
        best_pri  = '0;
        best_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (on_i[i] && (!found_o || pri_i[i] < best_pri ||
                (pri_i[i] == best_pri && rank_i[i] < best_rank))) begin
                found_o   = 1'b1;
                idx_o     = IW'(i);
                best_pri  = pri_i[i];
                best_rank = rank_i[i];
            end
        end
    end
endmodule

// File: rtl/pa_policy_tbl.sv
// Versioned policy table, loaded in one cycle on commit.
module pa_policy_tbl #(
    parameter int N    = 4,
    parameter int PRIW = 2,
    parameter int PW   = 8,
    parameter int VW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_i,
    input  logic [N-1:0][PRIW-1:0] pri_i,
    input  logic [N-1:0]           strict_i,
    input  logic [N-1:0][PW-1:0]   cap_i,
    input  logic [VW-1:0]          ver_i,
    output logic [N-1:0][PRIW-1:0] pri_o,
    output logic [N-1:0]           strict_o,
    output logic [N-1:0][PW-1:0]   cap_o,
    output logic [VW-1:0]          ver_o
);
    typedef struct packed {
        logic [N-1:0][PRIW-1:0] pri;
        logic [N-1:0]           strict;
        logic [N-1:0][PW-1:0]   cap;
        logic [VW-1:0]          ver;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (commit_i) begin
            t_d.pri    = pri_i;
            t_d.strict = strict_i;
            t_d.cap    = cap_i;
            t_d.ver    = ver_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.pri    <= '0;
            t_q.strict <= '0;
            t_q.cap    <= '1;
            t_q.ver    <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pri_o    = t_q.pri;
    assign strict_o = t_q.strict;
    assign cap_o    = t_q.cap;
    assign ver_o    = t_q.ver;
endmodule

// File: rtl/pa_alloc.sv
module pa_alloc
    import pa_pkg::*;
#(
    parameter int NPORT    = 4,
    parameter int PW       = 8,
    parameter int CW       = 3,
    parameter int PRIW     = 2,
    parameter int VW       = 4,
    parameter int CLSTEP   = 8,
    parameter int CONS_PWR = 8,
    parameter int SAFE_CAP = 60,
    parameter int MIN_PWR  = 4,
    parameter int BACKOFF  = 16,
    localparam int IW      = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SUMW    = PW + $clog2(NPORT) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      req_i,
    input  logic [NPORT*CW-1:0]   cls_i,
    input  logic [NPORT-1:0]      amb_i,
    input  logic [NPORT-1:0]      rel_i,
    input  logic [SUMW-1:0]       total_i,
    input  logic [SUMW-1:0]       guard_i,
    input  logic [NPORT*PRIW-1:0] cfg_pri_i,
    input  logic [NPORT-1:0]      cfg_strict_i,
    input  logic [NPORT*PW-1:0]   cfg_cap_i,
    input  logic [VW-1:0]         cfg_ver_i,
    input  logic                  cfg_commit_i,
    output logic [NPORT-1:0]      on_o,
    output logic [NPORT-1:0]      shed_o,
    output logic [NPORT*PW-1:0]   alloc_o,
    output logic [SUMW-1:0]       sum_o,
    output logic                  evt_v_o,
    output logic [IW-1:0]         evt_port_o,
    output logic [2:0]            evt_code_o,
    output logic [VW-1:0]         ver_o
);
    localparam int RW = $clog2(NPORT + 1);
    localparam int BW = $clog2(BACKOFF + 1);

    typedef struct packed {
        logic [NPORT-1:0]         on;
        logic [NPORT-1:0][PW-1:0] alloc;
        logic [NPORT-1:0][RW-1:0] rank;
        logic [NPORT-1:0][BW-1:0] boff;
        logic [NPORT-1:0]         preq;
        logic [NPORT-1:0]         prel;
        logic [NPORT-1:0]         shed;
        logic [SUMW-1:0]          sum;
        logic                     ev_v;
        logic [IW-1:0]            ev_port;
        ev_code_e                 ev_code;
    } st_t;

    st_t s_d, s_q;

    logic [NPORT-1:0][PRIW-1:0] tbl_pri;
    logic [NPORT-1:0]           tbl_strict;
    logic [NPORT-1:0][PW-1:0]   tbl_cap;

    pa_policy_tbl #(.N(NPORT), .PRIW(PRIW), .PW(PW), .VW(VW)) i_tbl (
        .clk(clk), .rst_n(rst_n), .commit_i(cfg_commit_i),
        .pri_i(cfg_pri_i), .strict_i(cfg_strict_i), .cap_i(cfg_cap_i),
        .ver_i(cfg_ver_i), .pri_o(tbl_pri), .strict_o(tbl_strict),
        .cap_o(tbl_cap), .ver_o(ver_o)
    );

    logic [NPORT-1:0] req_all, rel_all;
    logic             req_f, rel_f, vic_f;
    logic [IW-1:0]    req_idx, rel_idx, vic_idx;

    assign req_all = s_q.preq | req_i;
    assign rel_all = s_q.prel | rel_i;

    pa_first_set #(.N(NPORT), .IW(IW)) i_req_pick (
        .vec_i(req_all), .found_o(req_f), .idx_o(req_idx));
    pa_first_set #(.N(NPORT), .IW(IW)) i_rel_pick (
        .vec_i(rel_all), .found_o(rel_f), .idx_o(rel_idx));
    pa_victim #(.N(NPORT), .IW(IW), .PRIW(PRIW), .RW(RW)) i_victim (
        .on_i(s_q.on), .pri_i(tbl_pri), .rank_i(s_q.rank),
        .found_o(vic_f), .idx_o(vic_idx));

    // Budget arithmetic
    logic [SUMW:0]   need;
    logic            over;
    logic [SUMW-1:0] head, want, cls_pw;

    always_comb begin
        need   = {1'b0, s_q.sum} + {1'b0, guard_i};
        over   = need > {1'b0, total_i};
        head   = over ? '0 : (total_i - s_q.sum - guard_i);
        cls_pw = (SUMW'(cls_i[req_idx*CW +: CW]) + SUMW'(1)) * SUMW'(CLSTEP);
        want   = amb_i[req_idx] ? SUMW'(CONS_PWR) : cls_pw;
        if (want > SUMW'(tbl_cap[req_idx])) want = SUMW'(tbl_cap[req_idx]);
        if (want > SUMW'(SAFE_CAP))         want = SUMW'(SAFE_CAP);
    end

    always_comb begin
        s_d      = s_q;
        s_d.shed = '0;
        s_d.ev_v = 1'b0;
        s_d.preq = req_all;
        s_d.prel = rel_all;
        for (int i = 0; i < NPORT; i++) begin
            if (s_q.boff[i] != '0) s_d.boff[i] = s_q.boff[i] - BW'(1);
        end

        if (over && vic_f) begin
            // shed the selected port and close its rank gap
            s_d.on[vic_idx]    = 1'b0;
            s_d.alloc[vic_idx] = '0;
            s_d.sum            = s_q.sum - SUMW'(s_q.alloc[vic_idx]);
            s_d.boff[vic_idx]  = BW'(BACKOFF);
            s_d.shed[vic_idx]  = 1'b1;
            for (int j = 0; j < NPORT; j++) begin
                if (s_q.on[j] && s_q.rank[j] > s_q.rank[vic_idx])
                    s_d.rank[j] = s_q.rank[j] - RW'(1);
            end
            s_d.ev_v    = 1'b1;
            s_d.ev_port = vic_idx;
            s_d.ev_code = EV_SHED;
        end else if (rel_f) begin
            s_d.prel[rel_idx] = 1'b0;
            if (s_q.on[rel_idx]) begin
                s_d.on[rel_idx]    = 1'b0;
                s_d.alloc[rel_idx] = '0;
                s_d.sum            = s_q.sum - SUMW'(s_q.alloc[rel_idx]);
                for (int j = 0; j < NPORT; j++) begin
                    if (s_q.on[j] && s_q.rank[j] > s_q.rank[rel_idx])
                        s_d.rank[j] = s_q.rank[j] - RW'(1);
                end
                s_d.ev_v    = 1'b1;
                s_d.ev_port = rel_idx;
                s_d.ev_code = EV_REL;
            end
        end else if (req_f) begin
            s_d.preq[req_idx] = 1'b0;
            if (!s_q.on[req_idx]) begin
                s_d.ev_v    = 1'b1;
                s_d.ev_port = req_idx;
                if (s_q.boff[req_idx] != '0) begin
                    s_d.ev_code = EV_DENY_BOFF;
                end else if (want <= head ||
                             (!tbl_strict[req_idx] && head >= SUMW'(MIN_PWR))) begin
                    s_d.ev_code        = (want <= head) ? EV_GRANT : EV_DOWN;
                    s_d.alloc[req_idx] = (want <= head) ? PW'(want) : PW'(head);
                    s_d.on[req_idx]    = 1'b1;
                    s_d.sum            = s_q.sum + SUMW'(s_d.alloc[req_idx]);
                    for (int j = 0; j < NPORT; j++) begin
                        if (s_q.on[j]) s_d.rank[j] = s_q.rank[j] + RW'(1);
                    end
                    s_d.rank[req_idx] = '0;
                end else begin
                    s_d.ev_code = EV_DENY_BUD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.on      <= '0;
            s_q.alloc   <= '0;
            s_q.rank    <= '0;
            s_q.boff    <= '0;
            s_q.preq    <= '0;
            s_q.prel    <= '0;
            s_q.shed    <= '0;
            s_q.sum     <= '0;
            s_q.ev_v    <= 1'b0;
            s_q.ev_port <= '0;
            s_q.ev_code <= EV_GRANT;
        end else begin
            s_q <= s_d;
        end
    end

    assign on_o       = s_q.on;
    assign shed_o     = s_q.shed;
    assign alloc_o    = s_q.alloc;
    assign sum_o      = s_q.sum;
    assign evt_v_o    = s_q.ev_v;
    assign evt_port_o = s_q.ev_port;
    assign evt_code_o = s_q.ev_code;
endmodule

// File: rtl/pa_alloc_chk.sv
module pa_alloc_chk #(
    parameter int NPORT    = 4,
    parameter int PW       = 8,
    parameter int VW       = 4,
    parameter int SAFE_CAP = 60,
    parameter int IW       = 2,
    parameter int SUMW     = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SUMW-1:0]     total_i,
    input logic [SUMW-1:0]     guard_i,
    input logic                cfg_commit_i,
    input logic [NPORT-1:0]    on_o,
    input logic [NPORT-1:0]    shed_o,
    input logic [NPORT*PW-1:0] alloc_o,
    input logic [SUMW-1:0]     sum_o,
    input logic                evt_v_o,
    input logic [IW-1:0]       evt_port_o,
    input logic [2:0]          evt_code_o,
    input logic [VW-1:0]       ver_o
);
    logic [SUMW-1:0] asum;
    logic            cap_ok;

    always_comb begin
        asum   = '0;
        cap_ok = 1'b1;
        for (int i = 0; i < NPORT; i++) begin
            asum = asum + SUMW'(alloc_o[i*PW +: PW]);
            if (alloc_o[i*PW +: PW] > PW'(SAFE_CAP)) cap_ok = 1'b0;
        end
    end

    // R4
    shed_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(shed_o));
    // R4
    shed_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|shed_o) |-> (evt_v_o && evt_code_o == 3'd4 && shed_o[evt_port_o] && !on_o[evt_port_o]));
    // R9
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == asum);
    // R2
    no_oversub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_v_o && (evt_code_o == 3'd0 || evt_code_o == 3'd1)) |->
        (({1'b0, sum_o} + {1'b0, $past(guard_i)}) <= {1'b0, $past(total_i)}));
    // R3
    deny_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_v_o && (evt_code_o == 3'd2 || evt_code_o == 3'd3)) |->
        ($stable(alloc_o) && $stable(on_o)));
    // R1
    safe_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok);
    // R8
    ver_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_commit_i) |-> $stable(ver_o));
endmodule

bind pa_alloc pa_alloc_chk #(
    .NPORT(NPORT), .PW(PW), .VW(VW), .SAFE_CAP(SAFE_CAP), .IW(IW), .SUMW(SUMW)
) i_chk (
    .clk(clk), .rst_n(rst_n), .total_i(total_i), .guard_i(guard_i),
    .cfg_commit_i(cfg_commit_i), .on_o(on_o), .shed_o(shed_o),
    .alloc_o(alloc_o), .sum_o(sum_o), .evt_v_o(evt_v_o),
    .evt_port_o(evt_port_o), .evt_code_o(evt_code_o), .ver_o(ver_o)
);

// File: tb/test_pa_alloc.sv
module test_pa_alloc;
    localparam int N = 4, PW = 8, CW = 3, PRIW = 2, VW = 4, SUMW = 11, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]      req_i = '0, amb_i = '0, rel_i = '0, cfg_strict_i = '0;
    logic [N*CW-1:0]   cls_i = '0;
    logic [SUMW-1:0]   total_i = 11'd200, guard_i = '0;
    logic [N*PRIW-1:0] cfg_pri_i = '0;
    logic [N*PW-1:0]   cfg_cap_i = '1;
    logic [VW-1:0]     cfg_ver_i = '0;
    logic              cfg_commit_i = 1'b0;
    logic [N-1:0]      on_o, shed_o;
    logic [N*PW-1:0]   alloc_o;
    logic [SUMW-1:0]   sum_o;
    logic              evt_v_o;
    logic [IW-1:0]     evt_port_o;
    logic [2:0]        evt_code_o;
    logic [VW-1:0]     ver_o;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pa_alloc i_pa_alloc (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic commit;
        @(negedge clk) cfg_commit_i = 1'b1;
        @(negedge clk) cfg_commit_i = 1'b0;
    endtask

    task automatic ask(input int p, input int c, input logic amb);
        @(negedge clk);
        cls_i[p*CW +: CW] = CW'(c);
        amb_i[p] = amb;
        req_i = N'(1) << p;
        @(negedge clk) req_i = '0;
    endtask

    task automatic release_port(input int p);
        @(negedge clk) rel_i = N'(1) << p;
        @(negedge clk) rel_i = '0;
    endtask

    task automatic set_total(input int t);
        @(negedge clk) total_i = SUMW'(t);
        @(negedge clk);
    endtask

    // {class, ambiguous, host cap, expected allocation}
    localparam logic [19:0] VEC [0:6] = '{
        {3'd0, 1'b0, 8'd255, 8'd8},
        {3'd3, 1'b0, 8'd255, 8'd32},
        {3'd7, 1'b0, 8'd255, 8'd60},
        {3'd6, 1'b0, 8'd255, 8'd56},
        {3'd5, 1'b0, 8'd20,  8'd20},
        {3'd2, 1'b1, 8'd255, 8'd8},
        {3'd7, 1'b1, 8'd5,   8'd5}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset on_o", 32'(on_o), 0);
        chk("reset sum_o", 32'(sum_o), 0);
        chk("reset evt_v_o", 32'(evt_v_o), 0);
        chk("reset ver_o R8", 32'(ver_o), 0);
        rst_n = 1'b1;

        // R1 class-to-power table on port 0
        foreach (VEC[k]) begin
            cfg_cap_i[7:0] = VEC[k][15:8];
            cfg_ver_i = 4'd1;
            commit();
            ask(0, int'(VEC[k][19:17]), VEC[k][16]);
            chk($sformatf("R1 vec%0d alloc", k), 32'(alloc_o[7:0]), 32'(VEC[k][7:0]));
            chk($sformatf("R2 vec%0d code", k), 32'(evt_code_o), 0);
            release_port(0);
            chk($sformatf("R10 vec%0d code", k), 32'(evt_code_o), 5);
            chk($sformatf("R9 vec%0d sum", k), 32'(sum_o), 0);
        end

        // Table: pri p0=3 p1=1 p2=1 p3=2, p3 strict
        total_i = 11'd100;
        guard_i = 11'd10;
        cfg_pri_i = {2'd2, 2'd1, 2'd1, 2'd3};
        cfg_strict_i = 4'b1000;
        cfg_cap_i = '1;
        cfg_ver_i = 4'd5;
        commit();
        chk("R8 version", 32'(ver_o), 5);

        // R8 staged but uncommitted cap has no effect
        cfg_cap_i[7:0] = 8'd10;
        cfg_ver_i = 4'd6;
        ask(0, 3, 1'b0);
        chk("R8 uncommitted cap", 32'(alloc_o[7:0]), 32);
        chk("R8 version held", 32'(ver_o), 5);
        cfg_cap_i = '1;

        // R7 two requests in one cycle: port 1 first, then port 2
        @(negedge clk);
        cls_i[1*CW +: CW] = 3'd1;
        cls_i[2*CW +: CW] = 3'd3;
        req_i = 4'b0110;
        @(negedge clk) req_i = '0;
        chk("R7 first port", 32'(evt_port_o), 1);
        chk("R7 first alloc", 32'(alloc_o[15:8]), 16);
        chk("R7 second not yet on", 32'(on_o[2]), 0);
        @(negedge clk);
        chk("R7 second port", 32'(evt_port_o), 2);
        chk("R9 sum after two", 32'(sum_o), 80);

        // R3 strict port denied, powered ports untouched
        ask(3, 3, 1'b0);
        chk("R3 strict deny code", 32'(evt_code_o), 2);
        chk("R3 deny on_o", 32'(on_o), 32'b0111);
        chk("R3 deny sum", 32'(sum_o), 80);

        // R3 downgrade after strict bit cleared
        cfg_strict_i = '0;
        cfg_ver_i = 4'd7;
        commit();
        ask(3, 3, 1'b0);
        chk("R3 downgrade code", 32'(evt_code_o), 1);
        chk("R3 downgrade alloc", 32'(alloc_o[31:24]), 10);
        chk("R9 sum full", 32'(sum_o), 90);

        release_port(3);
        chk("R10 release code", 32'(evt_code_o), 5);
        chk("R10 release sum", 32'(sum_o), 80);

        // R5 equal priority: newest (port 2) shed first
        set_total(70);
        chk("R5 shed port", 32'(evt_port_o), 2);
        chk("R4 shed pulse", 32'(shed_o), 32'b0100);
        chk("R4 shed code", 32'(evt_code_o), 4);
        chk("R9 sum after shed", 32'(sum_o), 48);
        @(negedge clk);
        chk("R4 shed stops", 32'(shed_o), 0);

        set_total(50);
        chk("R4 second shed port", 32'(evt_port_o), 1);
        chk("R9 sum second shed", 32'(sum_o), 32);

        // R6 backoff
        ask(2, 1, 1'b0);
        chk("R6 backoff deny", 32'(evt_code_o), 3);
        chk("R6 backoff off", 32'(on_o[2]), 0);
        repeat (20) @(negedge clk);
        total_i = 11'd100;
        ask(2, 1, 1'b0);
        chk("R6 after backoff code", 32'(evt_code_o), 0);
        chk("R6 after backoff alloc", 32'(alloc_o[23:16]), 16);
        ask(3, 1, 1'b0);
        chk("R2 port3 grant", 32'(alloc_o[31:24]), 16);

        // R4 priority beats recency: port 2 (pri 1) before newer port 3 (pri 2)
        set_total(70);
        chk("R4 priority shed port", 32'(evt_port_o), 2);
        chk("R9 sum pri shed", 32'(sum_o), 48);

        // R2 exact fit: headroom 70-48-6 = 16
        guard_i = 11'd6;
        ask(1, 1, 1'b0);
        chk("R2 exact fit code", 32'(evt_code_o), 0);
        chk("R2 exact fit alloc", 32'(alloc_o[15:8]), 16);
        @(negedge clk);
        chk("R4 boundary no shed", 32'(shed_o), 0);
        chk("R4 boundary on_o", 32'(on_o), 32'b1011);
        chk("R9 boundary sum", 32'(sum_o), 64);

        summary();
    end
endmodule